// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out the four multi-register stack instructions of a CPU with sixteen 32-bit registers. An instruction names a half of the register file (R0 to R7 or R8 to R15) and an 8-bit selection mask over that half. A pop-style load fetches one word per selected register from the stack and moves the stack pointer upward. A push-style store moves the stack pointer downward before each write. The block drives a single word memory port, a register read index for store data, and a write-back strobe for loaded data. When it finishes it presents the final stack pointer together with a one-cycle completion pulse. Condition flags are not touched, and the block has no flag port.

The instruction is offered with `start`, the opcode, the mask and the current stack pointer. Each register transfer occupies a fixed slot of `STEP_CYC` cycles. The exception is the last transfer of a load, which occupies `LAST_LD_CYC` cycles, so the total latency depends only on the kind of instruction and the number of selected registers. The register file is written by the caller: the loaded registers come through the write-back strobe, and the stack pointer is updated from `sp_out` on the completion pulse.

Top module: `ldm_stm_seq`

## Requirements
- R1: Opcode 8'h8C is a load over R0..R7, 8'h8D a load over R8..R15, 8'h8E a store over R0..R7 and 8'h8F a store over R8..R15; mask bit i selects register 8*h+i, where h is opcode bit 0. Any other opcode, and any `start` while an instruction is in progress, is ignored: it causes no memory access, no write-back, no `done` and no change to the running transfer.
- R2: A load with initial pointer S visits the selected registers in ascending index order. Its k-th access (k from 0) reads address S+4k with `mem_we`=0. In that same cycle it asserts `wb_en` with `wb_idx` equal to the register and `wb_data` equal to `mem_rdata`.
- R3: A store with initial pointer S visits the selected registers in descending index order. Its k-th access writes address S-4(k+1) with `mem_we`=1, and `mem_wdata` is the register value returned on `reg_rd_data` for `reg_rd_idx`. A store followed by a load with the same mask and matching pointer restores the same register values.
- R4: The cycle in which `start` is accepted is cycle 0. A load with n≥1 selected registers asserts `done` in cycle STEP_CYC*(n-1)+LAST_LD_CYC, which is STEP_CYC*(n-1)+LAST_LD_CYC+1 cycles in total. Accesses are issued in the first cycle of each slot, starting in cycle 1.
- R5: A store with n≥1 selected registers asserts `done` in cycle STEP_CYC*n, which is STEP_CYC*n+1 cycles in total. Its accesses follow the same slot rule as in R4.
- R6: In the `done` cycle, `sp_out` equals S+4n for a load and S-4n for a store.
- R7: An empty mask with a valid opcode asserts `done` in cycle 0 with `sp_out`=S and makes no memory access.
- R8: A load that selects R15 performs its memory read but asserts no write-back for it, because the final pointer on `sp_out` takes its place. A store that selects R15 writes S, the pointer value from the start of the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Offer an instruction this cycle |
| op | input | 8 | Opcode |
| mask | input | 8 | Register selection within the chosen half |
| sp_in | input | AW | Stack pointer at instruction start |
| reg_rd_idx | output | 4 | Register whose value is needed for a store |
| reg_rd_data | input | DW | Value of register `reg_rd_idx`, same cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Load data for `mem_addr`, same cycle |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 4 | Register to write |
| wb_data | output | DW | Value to write |
| sp_out | output | AW | Final stack pointer, valid with `done` |
| done | output | 1 | Instruction completes this cycle |

## Verification
The assertions assume a memory that returns read data in the cycle of the request, a register file that answers `reg_rd_idx` combinationally, and a stack pointer that does not wrap around the address space during one instruction. The bench models both storage arrays combinationally. It draws pointers from a window well away from address zero and the top of its memory model, and it holds `start` high after acceptance only in the deliberate busy-collision cases. Everything the block outputs is therefore determined by the opcode, the mask and the starting pointer, and the bench rebuilds each expected transfer sequence from those alone.

// File: rtl/ldm_stm_seq.sv
module ldm_stm_seq #(
  parameter int DW          = 32,
  parameter int AW          = 32,
  parameter int STEP_CYC    = 2,
  parameter int LAST_LD_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    op,
  input  logic [7:0]    mask,
  input  logic [AW-1:0] sp_in,
  output logic [3:0]    reg_rd_idx,
  input  logic [DW-1:0] reg_rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_en,
  output logic [3:0]    wb_idx,
  output logic [DW-1:0] wb_data,
  output logic [AW-1:0] sp_out,
  output logic          done
);
  localparam int MAXC = (STEP_CYC > LAST_LD_CYC) ? STEP_CYC : LAST_LD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [AW-1:0] WSTEP = AW'(4);

  function automatic int popcnt(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  logic          busy, is_ld, bank;
  logic [7:0]    rem;
  logic [CW-1:0] cyc;
  logic [AW-1:0] sp_cur, sp_start, sp_fin;
  logic [2:0]    lo_i, hi_i, sel;
  logic [3:0]    idx;
  logic          op_ok, accept, single, slot_end;
  int            slot_len;

  assign op_ok  = (op[7:2] == 6'b100011);
  assign accept = start & ~busy & op_ok;

  always_comb begin
    lo_i = '0;
    for (int i = 7; i >= 0; i--) if (rem[i]) lo_i = 3'(i);
    hi_i = '0;
    for (int i = 0; i < 8; i++) if (rem[i]) hi_i = 3'(i);
  end

  assign sel      = is_ld ? lo_i : hi_i;
  assign idx      = {bank, sel};
  assign single   = ((rem & (rem - 8'd1)) == 8'd0);
  assign slot_len = (is_ld && single) ? LAST_LD_CYC : STEP_CYC;
  assign slot_end = busy && (cyc == CW'(slot_len - 1));

  assign mem_req    = busy && (cyc == '0);
  assign mem_we     = mem_req & ~is_ld;
  assign mem_addr   = is_ld ? sp_cur : sp_cur - WSTEP;
  assign reg_rd_idx = idx;
  assign mem_wdata  = (idx == 4'hF) ? DW'(sp_start) : reg_rd_data;
  assign wb_en      = mem_req & is_ld & (idx != 4'hF);
  assign wb_idx     = idx;
  assign wb_data    = mem_rdata;
  assign done       = (accept && mask == 8'd0) || (slot_end && single);
  assign sp_out     = busy ? sp_fin : sp_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_ld    <= 1'b0;
      bank     <= 1'b0;
      rem      <= '0;
      cyc      <= '0;
      sp_cur   <= '0;
      sp_start <= '0;
      sp_fin   <= '0;
    end else if (accept) begin
      if (mask != 8'd0) begin
        busy     <= 1'b1;
        is_ld    <= ~op[1];
        bank     <= op[0];
        rem      <= mask;
        cyc      <= '0;
        sp_cur   <= sp_in;
        sp_start <= sp_in;
        sp_fin   <= op[1] ? sp_in - AW'(4 * popcnt(mask))
                          : sp_in + AW'(4 * popcnt(mask));
      end
    end else if (busy) begin
      if (slot_end) begin
        rem[sel] <= 1'b0;
        cyc      <= '0;
        sp_cur   <= is_ld ? sp_cur + WSTEP : sp_cur - WSTEP;
        if (single) busy <= 1'b0;
      end else begin
        cyc <= cyc + CW'(1);
      end
    end
  end

  int         chk_cnt, chk_n;
  logic [3:0] last_idx;
  logic       have_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_cnt   <= 0;
      chk_n     <= 0;
      last_idx  <= '0;
      have_last <= 1'b0;
    end else begin
      if (accept) begin
        chk_cnt   <= 1;
        chk_n     <= popcnt(mask);
        have_last <= 1'b0;
      end else begin
        if (busy) chk_cnt <= chk_cnt + 1;
        if (mem_req) begin
          last_idx  <= idx;
          have_last <= 1'b1;
        end
      end
    end
  end

  a_r4_r5_cycle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |-> (chk_cnt == (is_ld ? STEP_CYC * (chk_n - 1) + LAST_LD_CYC
                                          : STEP_CYC * chk_n)));

  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && is_ld && have_last) |-> (idx > last_idx));

  a_r3_descending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !is_ld && have_last) |-> (idx < last_idx));

  a_r7_empty_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mask == 8'd0) |=> !mem_req);

  a_r8_no_r15_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != 4'hF && !mem_we));

  a_r1_bad_opcode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_ok) |=> !mem_req);
endmodule

// File: tb/ldm_stm_seq_bench.sv
`timescale 1ns/1ps
module ldm_stm_seq_bench;
  localparam int A = 2;
  localparam int B = 3;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [7:0]  op = 0, mask = 0;
  logic [31:0] sp_in = 0;
  logic [3:0]  reg_rd_idx, wb_idx;
  logic [31:0] reg_rd_data, mem_addr, mem_wdata, mem_rdata, wb_data, sp_out;
  logic        mem_req, mem_we, wb_en, done;

  logic [31:0] regs [16];
  logic [31:0] mem  [128];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign reg_rd_data = regs[reg_rd_idx];
  assign mem_rdata   = mem[mem_addr[8:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[8:2]] <= mem_wdata;
    if (wb_en) regs[wb_idx] <= wb_data;
  end

  ldm_stm_seq #(.DW(32), .AW(32), .STEP_CYC(A), .LAST_LD_CYC(B)) u_ldm_stm_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mask(mask), .sp_in(sp_in),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .sp_out(sp_out), .done(done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] o, input logic [7:0] m, input logic [31:0] s, input bit noise);
    bit ld = ~o[1];
    int n = 0, k = 0, ei[8], exp_cyc;
    bit got = 0;
    logic [31:0] ea;
    if (ld) begin
      for (int i = 0; i < 8; i++) if (m[i]) begin ei[n] = int'(o[0]) * 8 + i; n++; end
    end else begin
      for (int i = 7; i >= 0; i--) if (m[i]) begin ei[n] = int'(o[0]) * 8 + i; n++; end
    end
    exp_cyc = (n == 0) ? 0 : (ld ? A * (n - 1) + B : A * n);
    @(negedge clk);
    start = 1; op = o; mask = m; sp_in = s;
    for (int c = 0; c <= exp_cyc + 4 && !got; c++) begin
      if (c > 0) begin
        @(negedge clk);
        if (c == 1) begin
          if (noise) begin op = 8'h8C; mask = 8'hFF; sp_in = 32'h40; end
          else start = 0;
        end
        if (c == 3) start = 0;
      end
      #1;
      if (mem_req) begin
        if (k < n) begin
          ea = ld ? s + 32'(4 * k) : s - 32'(4 * (k + 1));
          chk(mem_addr == ea, ld ? "R2 load address" : "R3 store address", mem_addr, ea);
          chk(mem_we == !ld, "R1 access direction", 32'(mem_we), 32'(!ld));
          if (ld) begin
            chk(wb_en == (ei[k] != 15), "R8 write-back enable", 32'(wb_en), 32'(ei[k] != 15));
            if (wb_en) begin
              chk(wb_idx == 4'(ei[k]), "R2 load order", 32'(wb_idx), 32'(ei[k]));
              chk(wb_data == mem[ea[8:2]], "R2 load data", wb_data, mem[ea[8:2]]);
            end
          end else begin
            chk(mem_wdata == ((ei[k] == 15) ? s : regs[ei[k]]),
                ei[k] == 15 ? "R8 stored pointer" : "R3 store data",
                mem_wdata, (ei[k] == 15) ? s : regs[ei[k]]);
          end
        end else begin
          chk(0, "R1 extra access", 32'(k), 32'(n));
        end
        k++;
      end
      if (done) begin
        got = 1;
        chk(c == exp_cyc, n == 0 ? "R7 empty latency" : (ld ? "R4 load latency" : "R5 store latency"),
            32'(c), 32'(exp_cyc));
        ea = ld ? s + 32'(4 * n) : s - 32'(4 * n);
        chk(sp_out == ea, "R6 final pointer", sp_out, ea);
      end
    end
    chk(got, "R4 done seen", 32'(got), 1);
    chk(k == n, "R1 access count", 32'(k), 32'(n));
    if (start) begin @(negedge clk); start = 0; end
  endtask

  task automatic bad_op(input logic [7:0] o);
    bit seen = 0;
    @(negedge clk);
    start = 1; op = o; mask = 8'hFF; sp_in = 32'h100;
    for (int c = 0; c < 6; c++) begin
      if (c > 0) begin @(negedge clk); start = 0; end
      #1;
      if (mem_req || done || wb_en) seen = 1;
    end
    chk(!seen, "R1 unknown opcode ignored", 32'(seen), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] saved [16];
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    for (int i = 0; i < 128; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    #1;
    chk(done == 0 && mem_req == 0 && wb_en == 0, "R1 reset idle", {29'd0, done, mem_req, wb_en}, 0);
    rst_n = 1;

    for (int i = 0; i < 16; i++) saved[i] = regs[i];
    run_op(8'h8F, 8'hFF, 32'h140, 0);
    run_op(8'h8D, 8'h7F, 32'h120, 0);
    for (int i = 8; i < 15; i++)
      chk(regs[i] == saved[i], "R3 round trip restores", regs[i], saved[i]);
    run_op(8'h8D, 8'h80, 32'h100, 0);
    chk(regs[15] == saved[15], "R8 loaded R15 discarded", regs[15], saved[15]);
    run_op(8'h8E, 8'h00, 32'h130, 0);
    run_op(8'h8C, 8'h00, 32'h130, 0);
    run_op(8'h8C, 8'h01, 32'h110, 0);
    run_op(8'h8E, 8'h80, 32'h110, 0);
    run_op(8'h8E, 8'hA5, 32'h150, 1);
    run_op(8'h8C, 8'h5A, 32'h150, 1);
    bad_op(8'h8B);
    bad_op(8'h0C);
    bad_op(8'h9C);
    run_op(8'h8F, 8'h81, 32'h160, 0);

    for (int t = 0; t < 300; t++) begin
      logic [7:0] o = 8'h8C + 8'($urandom % 4);
      logic [7:0] m = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
      logic [31:0] s = 32'h100 + 32'(($urandom % 32) * 4);
      bit nz = ($countones(m) >= 2) && ($urandom % 5 == 0);
      run_op(o, m, s, nz);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule